// File: doc/BRIEF.md
# Host Access Handshake with Wait-State and Zero-Wait Modes

This block sits between a host processor bus and a peripheral's internal storage. The internal storage is modelled as a small word memory with a fixed internal access time. The host starts an access by pulling an active-low strobe. With the strobe it presents a read/write select, an address and write data. The block then runs one internal transfer and reports progress on a single active-low ready pin. The meaning of that pin depends on the handshake mode.

In wait-state mode, ready going low tells the host that its cycle is finished. For a read, the data is valid; for a write, the word is stored. The host keeps the strobe low until it sees ready low, then releases it. In zero-wait mode, ready idles high and goes low only while an internal transfer is under way. The block captures the request on the accepting clock edge, so the host may drop the strobe at once. A strap input selects transparent operation (1) or buffered operation (0). In transparent operation, an active-low I/O-enable output opens external address and data buffers for the duration of each internal transfer.

Top module: `host_handshake`

## Requirements
- R1: After reset, ready_n and ioen_n are 1, rdata is 0 and every memory word reads as 0.
- R2: An access is accepted on the first rising edge that samples strb_n low while the block is idle, provided strb_n has been sampled high at some edge since the previous acceptance. In wait-state mode (wait_mode=1) with rd_nwr=1 (read), ready_n goes low on the LAT-th rising edge after the accepting edge, and rdata holds the addressed word at that point.
- R3: In wait-state mode with rd_nwr=0 (write), the word on wdata is stored at addr by the time ready_n goes low. This is on the same edge count as R2, and a later read returns the word.
- R4: In wait-state mode, ready_n stays low for as long as strb_n is held low. It returns to 1 on the first rising edge that samples strb_n high.
- R5: In zero-wait mode (wait_mode=0), ready_n is 1 while idle. It goes low on the accepting edge and stays low for exactly LAT clock cycles, then returns to 1.
- R6: In zero-wait mode, addr, wdata and rd_nwr are captured on the accepting edge. Changing them, or releasing strb_n, after that edge has no effect on the transfer.
- R7: A strobe that falls while a transfer is in progress is not accepted until the block is idle again. It is then accepted on the first idle edge, provided it is still low.
- R8: With xparent_strap=1, ioen_n is 0 for exactly the LAT cycles of each internal transfer. With xparent_strap=0, ioen_n stays 1.
- R9: rdata changes only when a read transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobe and request inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_n | input | 1 | Active-low host access strobe |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| wait_mode | input | 1 | 1 = wait-state handshake, 0 = zero-wait handshake; captured at acceptance |
| xparent_strap | input | 1 | 1 = transparent (buffer enable driven), 0 = buffered |
| rdata | output | DW | Read data, held until the next read completes |
| ready_n | output | 1 | Active-low ready: completion in wait-state mode, busy in zero-wait mode |
| ioen_n | output | 1 | Active-low external buffer enable during internal transfers |

## Verification
The interesting overlap is a new host strobe that falls in the same cycles as a zero-wait transfer still in flight. The bench provokes it by releasing the strobe right after acceptance, re-asserting it on the next cycle with a new address, and holding it low. Ready is then judged cycle by cycle: low for LAT cycles, high for exactly one cycle, then low again for the second transfer. Follow-up wait-state reads confirm that both words landed at their own addresses. A second overlap, the host altering address and data on the cycle after acceptance, is judged the same way by reading back the stored word.

// File: rtl/host_handshake.sv
module host_handshake #(
  parameter int DW  = 16,
  parameter int AW  = 6,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strb_n,
  input  logic          rd_nwr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wait_mode,
  input  logic          xparent_strap,
  output logic [DW-1:0] rdata,
  output logic          ready_n,
  output logic          ioen_n
);

  localparam int DEPTH = 1 << AW;
  localparam int CW    = (LAT > 1) ? $clog2(LAT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          armed;
  logic          wait_q;
  logic          rd_q;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [DW-1:0] mem [DEPTH];

  wire accept = (state == S_IDLE) && !strb_n && armed;
  wire finish = (state == S_BUSY) && (cnt == '0);

  assign ready_n = wait_q ? (state != S_DONE) : (state != S_BUSY);
  assign ioen_n  = !((state == S_BUSY) && xparent_strap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      armed  <= 1'b1;
      wait_q <= 1'b0;
      rd_q   <= 1'b0;
      a_q    <= '0;
      d_q    <= '0;
      rdata  <= '0;
    end else begin
      if (strb_n)      armed <= 1'b1;
      else if (accept) armed <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state  <= S_BUSY;
          cnt    <= CW'(LAT - 1);
          wait_q <= wait_mode;
          rd_q   <= rd_nwr;
          a_q    <= addr;
          d_q    <= wdata;
        end
        S_BUSY: begin
          if (cnt == '0) begin
            if (rd_q) rdata <= mem[a_q];
            state <= wait_q ? S_DONE : S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_DONE: if (strb_n) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (finish && !rd_q) begin
      mem[a_q] <= d_q;
    end
  end

  a_r4_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && !strb_n) |=> !ready_n);

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && strb_n) |=> ready_n);

  a_r5_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wait_mode) |=> !ready_n);

  a_r7_no_early_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY && cnt != '0) |=> (state == S_BUSY));

  a_r9_rdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !(finish && rd_q) |=> $stable(rdata));

  a_r8_ioen_strap: assert property (@(posedge clk) disable iff (!rst_n)
    !xparent_strap |-> ioen_n);

endmodule

// File: tb/test_host_handshake.sv
module test_host_handshake;
  localparam int  DW  = 16;
  localparam int  AW  = 6;
  localparam time TCK = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strb_n [2];
  logic          rd_nwr [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wdata [2];
  logic          wait_mode [2];
  logic          xparent_strap [2];
  logic [DW-1:0] rdata [2];
  logic          ready_n [2];
  logic          ioen_n [2];

  logic [DW-1:0] shadow [2][1<<AW];
  logic [DW-1:0] last_rd [2];
  int n_chk = 0;
  int n_bad = 0;

  always #(TCK/2) clk = ~clk;

  for (genvar g = 0; g < 2; g++) begin : g_dut
    host_handshake #(.DW(DW), .AW(AW), .LAT(g == 0 ? 1 : 3)) i_host_handshake (
      .clk(clk), .rst_n(rst_n), .strb_n(strb_n[g]), .rd_nwr(rd_nwr[g]),
      .addr(addr[g]), .wdata(wdata[g]), .wait_mode(wait_mode[g]),
      .xparent_strap(xparent_strap[g]), .rdata(rdata[g]),
      .ready_n(ready_n[g]), .ioen_n(ioen_n[g]));
  end

  function automatic int lat_of(int k);
    return (k == 0) ? 1 : 3;
  endfunction

  function automatic logic exp_ioen(logic strap, int n, int lat);
    return !(strap && n >= 1 && n <= lat);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_access(int k, logic wr, logic [AW-1:0] a, logic [DW-1:0] d, logic strap);
    int n = 0;
    int lat = lat_of(k);
    @(negedge clk);
    rd_nwr[k] = !wr; addr[k] = a; wdata[k] = d;
    wait_mode[k] = 1'b1; xparent_strap[k] = strap; strb_n[k] = 1'b0;
    for (int i = 1; i <= lat + 1; i++) begin
      @(negedge clk);
      n = i;
      chk(ioen_n[k] == exp_ioen(strap, n, lat), "R8 ioen during wait access", ioen_n[k], exp_ioen(strap, n, lat));
      if (i <= lat) begin
        chk(ready_n[k] == 1'b1, "R2 ready early", ready_n[k], 1);
        chk(rdata[k] == last_rd[k], "R9 rdata steady", rdata[k], last_rd[k]);
      end
    end
    chk(ready_n[k] == 1'b0, wr ? "R3 ready on write" : "R2 ready on read", ready_n[k], 0);
    if (wr) shadow[k][a] = d;
    else begin
      chk(rdata[k] == shadow[k][a], "R2 read data", rdata[k], shadow[k][a]);
      last_rd[k] = shadow[k][a];
    end
    @(negedge clk);
    chk(ready_n[k] == 1'b0, "R4 ready held", ready_n[k], 0);
    strb_n[k] = 1'b1;
    @(negedge clk);
    chk(ready_n[k] == 1'b1, "R4 ready released", ready_n[k], 1);
  endtask

  task automatic zw_access(int k, logic wr, logic [AW-1:0] a, logic [DW-1:0] d, logic strap);
    int lat = lat_of(k);
    @(negedge clk);
    chk(ready_n[k] == 1'b1, "R5 idle ready", ready_n[k], 1);
    rd_nwr[k] = !wr; addr[k] = a; wdata[k] = d;
    wait_mode[k] = 1'b0; xparent_strap[k] = strap; strb_n[k] = 1'b0;
    for (int i = 1; i <= lat + 1; i++) begin
      @(negedge clk);
      if (i == 1) begin
        strb_n[k] = 1'b1;
        addr[k] = ~a; wdata[k] = ~d; rd_nwr[k] = wr;
      end
      chk(ready_n[k] == (i > lat), "R5 busy window", ready_n[k], i > lat);
      chk(ioen_n[k] == exp_ioen(strap, i, lat), "R8 ioen during zero-wait", ioen_n[k], exp_ioen(strap, i, lat));
    end
    if (wr) shadow[k][a] = d;
    else begin
      chk(rdata[k] == shadow[k][a], "R6 zero-wait read data", rdata[k], shadow[k][a]);
      last_rd[k] = shadow[k][a];
    end
  endtask

  task automatic held_off(int k, logic [AW-1:0] a1, logic [DW-1:0] d1, logic [AW-1:0] a2, logic [DW-1:0] d2);
    int lat = lat_of(k);
    @(negedge clk);
    rd_nwr[k] = 1'b0; addr[k] = a1; wdata[k] = d1;
    wait_mode[k] = 1'b0; xparent_strap[k] = 1'b1; strb_n[k] = 1'b0;
    @(negedge clk);
    strb_n[k] = 1'b1; addr[k] = '0; wdata[k] = '0;
    chk(ready_n[k] == 1'b0, "R7 first busy", ready_n[k], 0);
    @(negedge clk);
    strb_n[k] = 1'b0; addr[k] = a2; wdata[k] = d2;
    for (int i = 2; i <= lat + 2; i++) begin
      if (i > 2) @(negedge clk);
      chk(ready_n[k] == (i == lat + 1), "R7 hold-off pattern", ready_n[k], i == lat + 1);
    end
    strb_n[k] = 1'b1; addr[k] = '0;
    shadow[k][a1] = d1; shadow[k][a2] = d2;
    for (int i = 0; i < lat; i++) @(negedge clk);
    chk(ready_n[k] == 1'b1, "R7 second done", ready_n[k], 1);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 2; k++) begin
      strb_n[k] = 1'b1; rd_nwr[k] = 1'b1; addr[k] = '0; wdata[k] = '0;
      wait_mode[k] = 1'b1; xparent_strap[k] = 1'b1; last_rd[k] = '0;
      for (int j = 0; j < (1 << AW); j++) shadow[k][j] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      chk(ready_n[k] == 1'b1, "R1 reset ready", ready_n[k], 1);
      chk(ioen_n[k] == 1'b1, "R1 reset ioen", ioen_n[k], 1);
      chk(rdata[k] == '0, "R1 reset rdata", rdata[k], 0);
    end
    for (int k = 0; k < 2; k++) begin
      wait_access(k, 1'b0, 6'd5, '0, 1'b1);
      wait_access(k, 1'b1, 6'd9, '0, 1'b0);
      wait_access(k, 1'b1, 6'd9, 16'hA5C3, 1'b1);
      wait_access(k, 1'b0, 6'd9, '0, 1'b1);
      zw_access(k, 1'b1, 6'd12, 16'h1234, 1'b1);
      wait_access(k, 1'b0, 6'd12, '0, 1'b0);
      wait_access(k, 1'b0, ~6'd12, '0, 1'b0);
      zw_access(k, 1'b0, 6'd12, '0, 1'b0);
      held_off(k, 6'd20, 16'hBEEF, 6'd21, 16'hCAFE);
      wait_access(k, 1'b0, 6'd20, '0, 1'b1);
      wait_access(k, 1'b0, 6'd21, '0, 1'b1);
      wait_access(k, 1'b0, 6'd63, '0, 1'b1);
      for (int r = 0; r < 60; r++) begin
        logic [AW-1:0] ra = AW'($urandom_range(0, 7));
        logic [DW-1:0] rd = DW'($urandom);
        logic wr = 1'($urandom);
        logic st = 1'($urandom);
        if ($urandom_range(0, 1) == 1) wait_access(k, wr, ra, rd, st);
        else zw_access(k, wr, ra, rd, st);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule